// File: doc/BRIEF.md
# Palette Control Register File with Reset Detection

This block is a small register file for a color palette controller. The host writes it over a register-select bus with a data byte and a write strobe. It holds five registers: output multiplexing control, input clock selection, output clock selection, palette page and read mask. It also forms the palette RAM address from each incoming pixel index. The page register fills the upper address bits that a narrow pixel does not supply. The read mask is then ANDed with the merged address.

There are three ways to return the block to its pass-through defaults. The power-on reset input is asynchronous. A hardware reset is a strobe edge while the select bus carries its all-ones code. A software reset is a write to the mux control register whose low six bits hold the pass-through code. The write strobe can come from another clock domain: it passes through a parameterised synchroniser and an edge detector, and only its rising edge acts. The host holds select and data steady for as long as the strobe is high.

Top module: `pcr_palette_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the registers hold their defaults: `mux_ctl`=2Dh, `in_clk_sel`=00h, `out_clk_sel`=3Fh, `page_reg`=00h, `read_mask`=FFh.
- R2: A rising edge of `wr_strobe` stores `wr_data` into the register chosen by `reg_sel`. The codes are 0 for mux control, 1 for input clock select, 2 for output clock select, 3 for palette page and 4 for read mask. A strobe held high writes once, so data changed after the edge is not stored.
- R3: A rising edge of `wr_strobe` with `reg_sel` = 1111b returns every register to its R1 default, whatever `wr_data` holds. Repeated strobes of this kind each reapply the defaults.
- R4: A write to mux control with `wr_data[5:0]` = 2Dh returns every register to its R1 default, and `mux_ctl` reads 2Dh even when `wr_data[7:6]` are set. Any other mux value is stored as written.
- R5: A strobe with `reg_sel` in the range 5 to 14 changes no register.
- R6: `depth_sel` selects the pixel depth: 00b gives 1 bit, 01b gives 2 bits, 10b gives 4 bits and 11b gives 8 bits. The low pixel-depth bits of the merged address come from `pixel_idx`, and the remaining upper bits come from `page_reg`.
- R7: At 8 bits per pixel (`depth_sel` = 11b), `page_reg` has no effect on `pal_addr`.
- R8: `pal_addr` is the merged address ANDed bit by bit with `read_mask`. A zero mask gives address 0 whatever `page_reg` holds.
- R9: `pass_through` is high exactly when `mux_ctl[5:0]` equals 2Dh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reg_sel | input | SEL_W | Register select code |
| wr_data | input | DATA_W | Write data |
| wr_strobe | input | 1 | Write strobe; acts on its rising edge |
| pixel_idx | input | DATA_W | Pixel index from the pixel path |
| depth_sel | input | 2 | Pixel depth code (1, 2, 4 or 8 bits) |
| pal_addr | output | DATA_W | Masked palette RAM address |
| mux_ctl | output | DATA_W | Mux control register |
| in_clk_sel | output | DATA_W | Input clock select register |
| out_clk_sel | output | DATA_W | Output clock select register |
| page_reg | output | DATA_W | Palette page register |
| read_mask | output | DATA_W | Read mask register |
| pass_through | output | 1 | Pass-through mode indicator |

## Verification
The assertions check on every cycle that a strobe edge lasts one cycle and that registers hold steady when no edge arrives. They also check that each reset trigger leaves all five defaults in the next cycle, that no address bit outside the mask is ever set, and that the page does not reach the address at 8-bit depth. Only the bench scenarios show the exact merge of page and pixel bits at each depth, that data changed during a held strobe is not stored, that the unused select codes are ignored, and that a mux value close to the pass-through code does not trigger a reset.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
   // register select codes (hardware reset uses all ones of the select width)
   localparam int unsigned SEL_MUX    = 0;
   localparam int unsigned SEL_INCLK  = 1;
   localparam int unsigned SEL_OUTCLK = 2;
   localparam int unsigned SEL_PAGE   = 3;
   localparam int unsigned SEL_MASK   = 4;

   // defaults applied by every reset source
   localparam logic [7:0] DEF_MUX    = 8'h2D;
   localparam logic [7:0] DEF_INCLK  = 8'h00;
   localparam logic [7:0] DEF_OUTCLK = 8'h3F;
   localparam logic [7:0] DEF_PAGE   = 8'h00;

   // low six mux bits that select pass-through mode
   localparam logic [5:0] PASS_CODE  = 6'h2D;

   typedef struct packed {
      logic [7:0] mux;
      logic [7:0] inclk;
      logic [7:0] outclk;
      logic [7:0] page;
      logic [7:0] mask;
   } pcr_regs_t;
endpackage

// File: rtl/pcr_strobe_edge.sv
module pcr_strobe_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_in,
   output logic rise_pulse
);
   logic s_sync;
   logic s_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign s_sync = strobe_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= (chain << 1) | SYNC_STAGES'(strobe_in);
         end
         assign s_sync = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= 1'b0;
      else        s_prev <= s_sync;
   end

   assign rise_pulse = s_sync & ~s_prev;

   // R2: a held strobe produces a single write pulse
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/pcr_regfile.sv
module pcr_regfile
   import pcr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_pulse,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] mux_ctl,
   output logic [DATA_W-1:0] in_clk_sel,
   output logic [DATA_W-1:0] out_clk_sel,
   output logic [DATA_W-1:0] page_reg,
   output logic [DATA_W-1:0] read_mask
);
   localparam logic [DATA_W-1:0] D_MUX    = DATA_W'(DEF_MUX);
   localparam logic [DATA_W-1:0] D_INCLK  = DATA_W'(DEF_INCLK);
   localparam logic [DATA_W-1:0] D_OUTCLK = DATA_W'(DEF_OUTCLK);
   localparam logic [DATA_W-1:0] D_PAGE   = DATA_W'(DEF_PAGE);
   localparam logic [DATA_W-1:0] D_MASK   = {DATA_W{1'b1}};
   localparam logic [SEL_W-1:0]  HW_CODE  = {SEL_W{1'b1}};

   logic sel_mux, sel_in, sel_out, sel_page, sel_mask;
   logic hw_reset, sw_reset, any_reset;

   assign sel_mux  = reg_sel == SEL_W'(SEL_MUX);
   assign sel_in   = reg_sel == SEL_W'(SEL_INCLK);
   assign sel_out  = reg_sel == SEL_W'(SEL_OUTCLK);
   assign sel_page = reg_sel == SEL_W'(SEL_PAGE);
   assign sel_mask = reg_sel == SEL_W'(SEL_MASK);

   assign hw_reset  = wr_pulse && (reg_sel == HW_CODE);
   assign sw_reset  = wr_pulse && sel_mux && (wr_data[5:0] == PASS_CODE);
   assign any_reset = hw_reset || sw_reset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mux_ctl     <= D_MUX;
         in_clk_sel  <= D_INCLK;
         out_clk_sel <= D_OUTCLK;
         page_reg    <= D_PAGE;
         read_mask   <= D_MASK;
      end else if (any_reset) begin
         mux_ctl     <= D_MUX;
         in_clk_sel  <= D_INCLK;
         out_clk_sel <= D_OUTCLK;
         page_reg    <= D_PAGE;
         read_mask   <= D_MASK;
      end else if (wr_pulse) begin
         if (sel_mux)  mux_ctl     <= wr_data;
         if (sel_in)   in_clk_sel  <= wr_data;
         if (sel_out)  out_clk_sel <= wr_data;
         if (sel_page) page_reg    <= wr_data;
         if (sel_mask) read_mask   <= wr_data;
      end
   end

   // R3: hardware reset strobe leaves all defaults
   a_r3_hw_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pulse && reg_sel == HW_CODE) |=>
         (mux_ctl == D_MUX && in_clk_sel == D_INCLK && out_clk_sel == D_OUTCLK
          && page_reg == D_PAGE && read_mask == D_MASK));

   // R4: pass-through code written to mux leaves all defaults
   a_r4_sw_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pulse && reg_sel == SEL_W'(SEL_MUX) && wr_data[5:0] == PASS_CODE) |=>
         (mux_ctl == D_MUX && in_clk_sel == D_INCLK && out_clk_sel == D_OUTCLK
          && page_reg == D_PAGE && read_mask == D_MASK));

   // R2, R5: without a write pulse nothing changes
   a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pulse |=> ($stable(mux_ctl) && $stable(in_clk_sel) && $stable(out_clk_sel)
                     && $stable(page_reg) && $stable(read_mask)));
endmodule

// File: rtl/pcr_addr_mask.sv
module pcr_addr_mask #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] pixel_idx,
   input  logic [1:0]        depth_sel,
   input  logic [DATA_W-1:0] page_reg,
   input  logic [DATA_W-1:0] read_mask,
   output logic [DATA_W-1:0] pal_addr
);
   logic [31:0] pix_bits;

   // depth code n selects 2**n pixel bits (1, 2, 4, 8)
   assign pix_bits = 32'd1 << depth_sel;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         logic merged;
         assign merged      = (32'(i) < pix_bits) ? pixel_idx[i] : page_reg[i];
         assign pal_addr[i] = merged & read_mask[i];
      end
   endgenerate
endmodule

// File: rtl/pcr_palette_ctrl.sv
module pcr_palette_ctrl
   import pcr_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SEL_W       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_strobe,
   input  logic [DATA_W-1:0] pixel_idx,
   input  logic [1:0]        depth_sel,
   output logic [DATA_W-1:0] pal_addr,
   output logic [DATA_W-1:0] mux_ctl,
   output logic [DATA_W-1:0] in_clk_sel,
   output logic [DATA_W-1:0] out_clk_sel,
   output logic [DATA_W-1:0] page_reg,
   output logic [DATA_W-1:0] read_mask,
   output logic              pass_through
);
   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("pcr_palette_ctrl: DATA_W must be at least 8");
      end
      if (SEL_W < 3) begin : g_bad_sel
         $error("pcr_palette_ctrl: SEL_W must be at least 3");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("pcr_palette_ctrl: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic wr_pulse;

   pcr_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe_in  (wr_strobe),
      .rise_pulse (wr_pulse)
   );

   pcr_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_pulse    (wr_pulse),
      .reg_sel     (reg_sel),
      .wr_data     (wr_data),
      .mux_ctl     (mux_ctl),
      .in_clk_sel  (in_clk_sel),
      .out_clk_sel (out_clk_sel),
      .page_reg    (page_reg),
      .read_mask   (read_mask)
   );

   pcr_addr_mask #(.DATA_W(DATA_W)) u_addr (
      .pixel_idx (pixel_idx),
      .depth_sel (depth_sel),
      .page_reg  (page_reg),
      .read_mask (read_mask),
      .pal_addr  (pal_addr)
   );

   assign pass_through = (mux_ctl[5:0] == PASS_CODE);

   // R8: no address bit outside the read mask
   a_r8_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
      (pal_addr & ~read_mask) == '0);

   // R7: at 8-bit depth the page register does not reach the address
   a_r7_page_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_sel == 2'b11) |-> (pal_addr[7:0] == (pixel_idx[7:0] & read_mask[7:0])));

   // R9: pass-through flag tracks the mux register
   a_r9_pass_flag: assert property (@(posedge clk) disable iff (!rst_n)
      pass_through == (mux_ctl[5:0] == 6'h2D));
endmodule

// File: tb/tb_pcr_palette_ctrl.sv
module tb_pcr_palette_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_sel = '0;
   logic [7:0] wr_data = '0;
   logic       wr_strobe = 1'b0;
   logic [7:0] pixel_idx = '0;
   logic [1:0] depth_sel = '0;
   logic [7:0] pal_addr, mux_ctl, in_clk_sel, out_clk_sel, page_reg, read_mask;
   logic       pass_through;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   pcr_palette_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_data(wr_data),
      .wr_strobe(wr_strobe), .pixel_idx(pixel_idx), .depth_sel(depth_sel),
      .pal_addr(pal_addr), .mux_ctl(mux_ctl), .in_clk_sel(in_clk_sel),
      .out_clk_sel(out_clk_sel), .page_reg(page_reg), .read_mask(read_mask),
      .pass_through(pass_through)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act,
                      input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic host_write(input logic [3:0] sel, input logic [7:0] data);
      @(negedge clk);
      reg_sel = sel; wr_data = data; wr_strobe = 1'b1;
      repeat (5) @(negedge clk);
      wr_strobe = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic chk_defaults(input string req);
      chk(req, "mux_ctl", mux_ctl, 8'h2D);
      chk(req, "in_clk_sel", in_clk_sel, 8'h00);
      chk(req, "out_clk_sel", out_clk_sel, 8'h3F);
      chk(req, "page_reg", page_reg, 8'h00);
      chk(req, "read_mask", read_mask, 8'hFF);
   endtask

   task automatic addr_case(input string req, input logic [1:0] d, input logic [7:0] pix,
                            input logic [7:0] exp);
      @(negedge clk);
      depth_sel = d; pixel_idx = pix;
      #1;
      chk(req, "pal_addr", pal_addr, exp);
   endtask

   task automatic t_reset;
      chk_defaults("R1");
      chk("R9", "pass_through", {7'b0, pass_through}, 8'h01);
   endtask

   task automatic t_writes;
      host_write(4'd0, 8'h1E);
      chk("R2", "mux_ctl", mux_ctl, 8'h1E);
      chk("R9", "pass_through low", {7'b0, pass_through}, 8'h00);
      host_write(4'd1, 8'h5A);
      chk("R2", "in_clk_sel", in_clk_sel, 8'h5A);
      host_write(4'd2, 8'h12);
      chk("R2", "out_clk_sel", out_clk_sel, 8'h12);
      host_write(4'd3, 8'hA5);
      chk("R2", "page_reg", page_reg, 8'hA5);
      host_write(4'd4, 8'h7F);
      chk("R2", "read_mask", read_mask, 8'h7F);
      host_write(4'd4, 8'hFF);
   endtask

   task automatic t_held_strobe;
      @(negedge clk);
      reg_sel = 4'd1; wr_data = 8'h33; wr_strobe = 1'b1;
      repeat (5) @(negedge clk);
      wr_data = 8'h44;
      repeat (5) @(negedge clk);
      wr_strobe = 1'b0;
      repeat (5) @(negedge clk);
      chk("R2", "held strobe single write", in_clk_sel, 8'h33);
   endtask

   task automatic t_unused;
      for (int s = 5; s < 15; s++) host_write(4'(s), 8'hFF);
      chk("R5", "mux_ctl", mux_ctl, 8'h1E);
      chk("R5", "in_clk_sel", in_clk_sel, 8'h33);
      chk("R5", "out_clk_sel", out_clk_sel, 8'h12);
      chk("R5", "page_reg", page_reg, 8'hA5);
      chk("R5", "read_mask", read_mask, 8'hFF);
   endtask

   task automatic t_addr;
      // page A5, mask FF
      addr_case("R6", 2'b00, 8'hFF, 8'hA5);
      addr_case("R6", 2'b00, 8'h00, 8'hA4);
      addr_case("R6", 2'b01, 8'h02, 8'hA6);
      addr_case("R6", 2'b10, 8'h0C, 8'hAC);
      addr_case("R7", 2'b11, 8'h3C, 8'h3C);
      host_write(4'd3, 8'h5A);
      addr_case("R7", 2'b11, 8'h3C, 8'h3C);
      host_write(4'd3, 8'hA5);
      host_write(4'd4, 8'h0F);
      addr_case("R8", 2'b10, 8'h0C, 8'h0C);
      addr_case("R8", 2'b00, 8'h01, 8'h05);
      host_write(4'd4, 8'h00);
      addr_case("R8", 2'b00, 8'h01, 8'h00);
      addr_case("R8", 2'b11, 8'hFF, 8'h00);
   endtask

   task automatic t_hw_reset;
      host_write(4'd15, 8'h00);
      chk_defaults("R3");
      host_write(4'd3, 8'h11);
      host_write(4'd15, 8'hFF);
      host_write(4'd15, 8'h2C);
      chk_defaults("R3");
      chk("R1", "pass_through after reset", {7'b0, pass_through}, 8'h01);
   endtask

   task automatic t_sw_reset;
      host_write(4'd1, 8'h77);
      host_write(4'd2, 8'h12);
      host_write(4'd3, 8'h0C);
      host_write(4'd4, 8'h3C);
      host_write(4'd0, 8'h2C);
      chk("R4", "near code stored", mux_ctl, 8'h2C);
      chk("R4", "no reset on near code", page_reg, 8'h0C);
      host_write(4'd0, 8'hED);
      chk_defaults("R4");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_writes();
      t_held_strobe();
      t_unused();
      t_addr();
      t_hw_reset();
      t_sw_reset();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end
endmodule